// File: doc/BRIEF.md
# Prioritized Local Store Access Arbiter

This block sits in front of a single-ported scratchpad that holds 256 KB by default. Four agents compete for it: a memory-mapped register port, a block-transfer (DMA) engine, a processor load/store port and an instruction-fetch port. In every cycle the arbiter grants at most one of them by a fixed priority. The register port and the load/store port are narrow and move one 16-byte line per access. The DMA and fetch ports are wide and move one 128-byte block. Each requester drives its request with its address and data, and holds them until it sees its grant. A read returns its data in the cycle after the grant, tagged with the requester's identity.

The storage array is organised as rows of 128 bytes. It can only write whole 16-byte lines. A narrow write that starts off a line boundary, or that leaves some bytes disabled, is therefore carried out as a hidden read-modify-write. This takes two array cycles: the first reads the line and the second writes the merged line. No other requester is granted during those two cycles. A wide request whose address is not a multiple of 128 is granted so that its handshake completes, but it is not executed and is reported through an error pulse.

Top module: `lstore_arb`

## Requirements
- R1: While reset is applied and after it is released, with no request present, `rsp_valid`, `rsp_err` and all four grant outputs are low. Reset is asynchronous, active low, and is released internally two clock edges after `rst_n` rises.
- R2: At most one grant is high in any cycle. A grant goes only to a requesting port. Among the ports requesting in a non-busy cycle, the winner is the register port, then DMA, then load/store, then fetch. Grants are combinational in the request cycle.
- R3: A narrow read returns the 16-byte line that contains its address, so the low 4 address bits are ignored. The line appears in `rsp_data[127:0]` with the upper bits zero, in the cycle after the grant, with `rsp_valid` high. `rsp_id` carries the port's code: 0 for the register port, 1 for DMA, 2 for load/store and 3 for fetch.
- R4: A wide read whose address has its low 7 bits zero returns the 128-byte block in the cycle after the grant. Byte k of the block sits at `rsp_data[8k+7:8k]`, and byte 0 is the lowest address. The same byte order holds within a 16-byte line.
- R5: A wide request whose address has a nonzero value in its low 7 bits is granted. In the next cycle it raises `rsp_err` with its port code and leaves `rsp_valid` low. A write of this kind leaves the storage unchanged.
- R6: A narrow write with an aligned address and all 16 byte enables set completes in its grant cycle. It raises neither `rsp_valid` nor `rsp_err`, and another requester can be granted in the very next cycle.
- R7: A narrow write with an unaligned address or a partial byte mask blocks every grant in the cycle after its own grant. It raises neither `rsp_valid` nor `rsp_err`.
- R8: In such a write, with offset o equal to the low 4 address bits, write byte i with its enable set lands on line byte o+i whenever o+i < 16. Bytes that would fall past the end of the line are dropped. All other bytes of the line and of the memory keep their old values.
- R9: A wide write to an aligned address replaces all 128 bytes of the block in its grant cycle and raises no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mmio_req | input | 1 | Register port request |
| mmio_we | input | 1 | Register port write |
| mmio_addr | input | 18 | Register port byte address |
| mmio_wdata | input | 128 | Register port write line |
| mmio_be | input | 16 | Register port byte enables |
| mmio_gnt | output | 1 | Register port grant |
| dma_req | input | 1 | DMA request |
| dma_we | input | 1 | DMA write |
| dma_addr | input | 18 | DMA byte address |
| dma_wdata | input | 1024 | DMA write block |
| dma_gnt | output | 1 | DMA grant |
| ld_req | input | 1 | Load/store request |
| ld_we | input | 1 | Load/store write |
| ld_addr | input | 18 | Load/store byte address |
| ld_wdata | input | 128 | Load/store write line |
| ld_be | input | 16 | Load/store byte enables |
| ld_gnt | output | 1 | Load/store grant |
| if_req | input | 1 | Fetch read request |
| if_addr | input | 18 | Fetch byte address |
| if_gnt | output | 1 | Fetch grant |
| rsp_valid | output | 1 | Read data valid |
| rsp_err | output | 1 | Misaligned wide request reported |
| rsp_id | output | 2 | Port code of the response |
| rsp_data | output | 1024 | Read data |

## Verification
The bench first fills the checked region with wide writes. It then presents all four ports at once, so that the grant order and each port's tag can be told apart. Directed writes follow: an aligned full-mask write, an unaligned write that spills past the line end, and a partial-mask aligned write. Each is followed at once by a competing fetch. This separates a single-cycle write from a two-cycle merge and shows exactly which bytes changed. Misaligned wide reads and writes, followed by a read-back of the block, distinguish a rejected request from an executed one. A long random mix of ports, directions, offsets and masks is compared against a byte-level reference memory kept in the bench.

// File: rtl/lsarb_pkg.sv
`timescale 1ns/1ps
package lsarb_pkg;
  localparam int NPORT = 4;
  localparam int IDX_W = 2;
  // port codes, lower code wins arbitration
  localparam logic [IDX_W-1:0] ID_MMIO = 2'd0;
  localparam logic [IDX_W-1:0] ID_DMA  = 2'd1;
  localparam logic [IDX_W-1:0] ID_LDST = 2'd2;
  localparam logic [IDX_W-1:0] ID_IF   = 2'd3;
endpackage

// File: rtl/lsarb_prio.sv
`timescale 1ns/1ps
module lsarb_prio #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          busy,
  output logic [N-1:0]  gnt,
  output logic          gnt_any,
  output logic [IW-1:0] gnt_idx
);
  logic found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!busy && !found && req[i]) begin
        gnt[i]  = 1'b1;
        gnt_idx = IW'(i);
        found   = 1'b1;
      end
    end
    gnt_any = found;
  end

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (gnt == '0));
endmodule

// File: rtl/lsarb_merge.sv
`timescale 1ns/1ps
module lsarb_merge #(
  parameter int LINE_BYTES = 16,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES)
) (
  input  logic [LINE_W-1:0]     old_line,
  input  logic [LINE_W-1:0]     wdata,
  input  logic [LINE_BYTES-1:0] be,
  input  logic [OFF_W-1:0]      off,
  output logic [LINE_W-1:0]     new_line
);
  logic [LINE_W-1:0]     sh_data;
  logic [LINE_BYTES-1:0] sh_be;

  // shifting toward higher byte lanes drops what passes the line end
  assign sh_data = wdata << {off, 3'b000};
  assign sh_be   = be << off;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign new_line[b*8 +: 8] = sh_be[b] ? sh_data[b*8 +: 8] : old_line[b*8 +: 8];
  end
endmodule

// File: rtl/lsarb_bank.sv
`timescale 1ns/1ps
module lsarb_bank #(
  parameter int ROWS   = 2048,
  parameter int LANES  = 8,
  parameter int LINE_W = 128,
  localparam int ROW_W = $clog2(ROWS),
  localparam int ROW_BITS = LANES * LINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [ROW_W-1:0]    rd_row,
  input  logic [LANES-1:0]    wr_lane_en,
  input  logic [ROW_W-1:0]    wr_row,
  input  logic [ROW_BITS-1:0] wr_data,
  output logic [ROW_BITS-1:0] rd_data
);
  logic [ROW_BITS-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_row];
    for (int l = 0; l < LANES; l++) begin
      if (wr_lane_en[l]) mem[wr_row][l*LINE_W +: LINE_W] <= wr_data[l*LINE_W +: LINE_W];
    end
  end

  // single port: a read and a write never share a cycle
  assert_single_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (wr_lane_en != '0)));
endmodule

// File: rtl/lstore_arb.sv
`timescale 1ns/1ps
module lstore_arb
  import lsarb_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int LINE_BYTES  = 16,
  parameter int BLOCK_BYTES = 128,
  localparam int LINE_W  = LINE_BYTES * 8,
  localparam int BLOCK_W = BLOCK_BYTES * 8,
  localparam int LANES   = BLOCK_BYTES / LINE_BYTES,
  localparam int OFF_W   = $clog2(LINE_BYTES),
  localparam int BOFF_W  = $clog2(BLOCK_BYTES),
  localparam int LANE_W  = $clog2(LANES),
  localparam int ROW_W   = ADDR_W - BOFF_W,
  localparam int ROWS    = 1 << ROW_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mmio_req,
  input  logic                  mmio_we,
  input  logic [ADDR_W-1:0]     mmio_addr,
  input  logic [LINE_W-1:0]     mmio_wdata,
  input  logic [LINE_BYTES-1:0] mmio_be,
  output logic                  mmio_gnt,
  input  logic                  dma_req,
  input  logic                  dma_we,
  input  logic [ADDR_W-1:0]     dma_addr,
  input  logic [BLOCK_W-1:0]    dma_wdata,
  output logic                  dma_gnt,
  input  logic                  ld_req,
  input  logic                  ld_we,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  logic [LINE_W-1:0]     ld_wdata,
  input  logic [LINE_BYTES-1:0] ld_be,
  output logic                  ld_gnt,
  input  logic                  if_req,
  input  logic [ADDR_W-1:0]     if_addr,
  output logic                  if_gnt,
  output logic                  rsp_valid,
  output logic                  rsp_err,
  output logic [IDX_W-1:0]      rsp_id,
  output logic [BLOCK_W-1:0]    rsp_data
);
  // reset: asserted asynchronously, released after two edges
  logic rs_0, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_0   <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs_0   <= 1'b1;
      srst_n <= rs_0;
    end
  end

  // arbitration
  logic [NPORT-1:0] req, gnt;
  logic             gnt_any;
  logic [IDX_W-1:0] gnt_idx;
  logic             rmw_q;

  assign req = {if_req, ld_req, dma_req, mmio_req};

  lsarb_prio #(.N(NPORT)) u_prio (
    .clk(clk), .rst_n(srst_n), .req(req), .busy(rmw_q),
    .gnt(gnt), .gnt_any(gnt_any), .gnt_idx(gnt_idx)
  );

  assign mmio_gnt = gnt[ID_MMIO];
  assign dma_gnt  = gnt[ID_DMA];
  assign ld_gnt   = gnt[ID_LDST];
  assign if_gnt   = gnt[ID_IF];

  // winner's request
  logic [ADDR_W-1:0]     sel_addr;
  logic                  sel_we, sel_wide;
  logic [LINE_W-1:0]     sel_ndata;
  logic [LINE_BYTES-1:0] sel_be;

  always_comb begin
    sel_addr  = mmio_addr;
    sel_we    = mmio_we;
    sel_ndata = mmio_wdata;
    sel_be    = mmio_be;
    sel_wide  = 1'b0;
    unique case (gnt_idx)
      ID_DMA:  begin sel_addr = dma_addr; sel_we = dma_we; sel_wide = 1'b1; end
      ID_LDST: begin sel_addr = ld_addr; sel_we = ld_we; sel_ndata = ld_wdata; sel_be = ld_be; end
      ID_IF:   begin sel_addr = if_addr; sel_we = 1'b0; sel_wide = 1'b1; end
      default: ;
    endcase
  end

  logic [ROW_W-1:0]  sel_row;
  logic [LANE_W-1:0] sel_lane;
  logic [OFF_W-1:0]  sel_off;
  logic              sel_misal, sel_rmw, plain_wr;

  assign sel_row   = sel_addr[ADDR_W-1:BOFF_W];
  assign sel_lane  = sel_addr[BOFF_W-1:OFF_W];
  assign sel_off   = sel_addr[OFF_W-1:0];
  assign sel_misal = sel_wide && (sel_addr[BOFF_W-1:0] != '0);
  assign sel_rmw   = !sel_wide && sel_we && ((sel_off != '0) || (sel_be != '1));
  assign plain_wr  = gnt_any && sel_we && !sel_misal && !sel_rmw;

  // next state
  logic rmw_d, rmw_cap, rsp_valid_d, rsp_err_d;
  assign rmw_cap     = gnt_any && sel_rmw;
  assign rmw_d       = rmw_cap;
  assign rsp_valid_d = gnt_any && !sel_we && !sel_misal;
  assign rsp_err_d   = gnt_any && sel_misal;

  // state registers
  logic              rsp_valid_q, rsp_err_q, rsp_wide_q;
  logic [IDX_W-1:0]  rsp_id_q;
  logic [LANE_W-1:0] rsp_lane_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rmw_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
      rsp_id_q    <= '0;
      rsp_wide_q  <= 1'b0;
      rsp_lane_q  <= '0;
    end else begin
      rmw_q       <= rmw_d;
      rsp_valid_q <= rsp_valid_d;
      rsp_err_q   <= rsp_err_d;
      if (gnt_any) begin
        rsp_id_q   <= gnt_idx;
        rsp_wide_q <= sel_wide;
        rsp_lane_q <= sel_lane;
      end
    end
  end

  // merge operands held across the read phase
  logic [ROW_W-1:0]      rmw_row_q;
  logic [LANE_W-1:0]     rmw_lane_q;
  logic [OFF_W-1:0]      rmw_off_q;
  logic [LINE_W-1:0]     rmw_data_q;
  logic [LINE_BYTES-1:0] rmw_be_q;

  always_ff @(posedge clk) begin
    if (rmw_cap) begin
      rmw_row_q  <= sel_row;
      rmw_lane_q <= sel_lane;
      rmw_off_q  <= sel_off;
      rmw_data_q <= sel_ndata;
      rmw_be_q   <= sel_be;
    end
  end

  // array control
  logic                 rd_en;
  logic [LANES-1:0]     wr_lane_en;
  logic [ROW_W-1:0]     wr_row;
  logic [BLOCK_W-1:0]   wr_data, rd_data;
  logic [LINE_W-1:0]    old_line, merged_line;
  logic [LANES-1:0]     lane_one;

  assign lane_one = {{(LANES-1){1'b0}}, 1'b1};
  assign rd_en    = gnt_any && !sel_misal && (!sel_we || sel_rmw);
  assign old_line = rd_data[rmw_lane_q*LINE_W +: LINE_W];

  lsarb_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
    .old_line(old_line), .wdata(rmw_data_q), .be(rmw_be_q),
    .off(rmw_off_q), .new_line(merged_line)
  );

  always_comb begin
    wr_lane_en = '0;
    wr_row     = sel_row;
    wr_data    = {LANES{sel_ndata}};
    if (rmw_q) begin
      wr_lane_en = lane_one << rmw_lane_q;
      wr_row     = rmw_row_q;
      wr_data    = {LANES{merged_line}};
    end else if (plain_wr) begin
      if (sel_wide) begin
        wr_lane_en = '1;
        wr_data    = dma_wdata;
      end else begin
        wr_lane_en = lane_one << sel_lane;
      end
    end
  end

  lsarb_bank #(.ROWS(ROWS), .LANES(LANES), .LINE_W(LINE_W)) u_bank (
    .clk(clk), .rst_n(srst_n), .rd_en(rd_en), .rd_row(sel_row),
    .wr_lane_en(wr_lane_en), .wr_row(wr_row), .wr_data(wr_data),
    .rd_data(rd_data)
  );

  // response
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_id    = rsp_id_q;
  always_comb begin
    rsp_data = '0;
    if (rsp_valid_q) begin
      if (rsp_wide_q) rsp_data = rd_data;
      else            rsp_data = BLOCK_W'(rd_data[rsp_lane_q*LINE_W +: LINE_W]);
    end
  end

  assert_narrow_rd_next_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (mmio_gnt && !mmio_we) |=> (rsp_valid && rsp_id == ID_MMIO));
  assert_narrow_upper_zero_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (rsp_valid && (rsp_id == ID_MMIO || rsp_id == ID_LDST)) |-> (rsp_data[BLOCK_W-1:LINE_W] == '0));
  assert_wide_rd_next_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (if_gnt && if_addr[BOFF_W-1:0] == '0) |=> (rsp_valid && rsp_id == ID_IF));
  assert_misal_err_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (dma_gnt && dma_addr[BOFF_W-1:0] != '0) |=> (rsp_err && !rsp_valid && rsp_id == ID_DMA));
  assert_err_excl_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !(rsp_err && rsp_valid));
  assert_rmw_blocks_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (ld_gnt && ld_we && ld_addr[OFF_W-1:0] != '0) |=> !(mmio_gnt || dma_gnt || ld_gnt || if_gnt));
endmodule

// File: tb/lstore_arb_tb.sv
`timescale 1ns/1ps
module lstore_arb_tb;
  localparam int REF_BYTES = 2048;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic          mmio_req, mmio_we, mmio_gnt;
  logic [17:0]   mmio_addr;
  logic [127:0]  mmio_wdata;
  logic [15:0]   mmio_be;
  logic          dma_req, dma_we, dma_gnt;
  logic [17:0]   dma_addr;
  logic [1023:0] dma_wdata;
  logic          ld_req, ld_we, ld_gnt;
  logic [17:0]   ld_addr;
  logic [127:0]  ld_wdata;
  logic [15:0]   ld_be;
  logic          if_req, if_gnt;
  logic [17:0]   if_addr;
  logic          rsp_valid, rsp_err;
  logic [1:0]    rsp_id;
  logic [1023:0] rsp_data;

  lstore_arb u_dut (.*);

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [7:0] ref_mem [REF_BYTES];

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_line(input logic [17:0] a);
    logic [127:0] r;
    int base = int'(a[10:4]) * 16;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = ref_mem[base + b];
    return r;
  endfunction

  function automatic logic [1023:0] exp_block(input logic [17:0] a);
    logic [1023:0] r;
    int base = int'(a[10:7]) * 128;
    for (int b = 0; b < 128; b++) r[b*8 +: 8] = ref_mem[base + b];
    return r;
  endfunction

  // R8 reference merge
  task automatic ref_narrow(input logic [17:0] a, input logic [127:0] d, input logic [15:0] be);
    int base = int'(a[10:4]) * 16;
    int off = int'(a[3:0]);
    for (int i = 0; i < 16; i++)
      if (be[i] && off + i < 16) ref_mem[base + off + i] = d[i*8 +: 8];
  endtask

  task automatic ref_wide(input logic [17:0] a, input logic [1023:0] d);
    int base = int'(a[10:7]) * 128;
    for (int b = 0; b < 128; b++) ref_mem[base + b] = d[b*8 +: 8];
  endtask

  function automatic bit gnt_of(input int p);
    case (p)
      0: return mmio_gnt;
      1: return dma_gnt;
      2: return ld_gnt;
      default: return if_gnt;
    endcase
  endfunction

  task automatic drive(input int p, input bit r, input bit we, input logic [17:0] a,
                       input logic [127:0] nd, input logic [15:0] be, input logic [1023:0] wd);
    case (p)
      0: begin mmio_req = r; mmio_we = we; mmio_addr = a; mmio_wdata = nd; mmio_be = be; end
      1: begin dma_req = r; dma_we = we; dma_addr = a; dma_wdata = wd; end
      2: begin ld_req = r; ld_we = we; ld_addr = a; ld_wdata = nd; ld_be = be; end
      default: begin if_req = r; if_addr = a; end
    endcase
  endtask

  function automatic logic [1023:0] exp_rd(input int p, input logic [17:0] a);
    if (p == 1 || p == 3) return exp_block(a);
    return {896'b0, exp_line(a)};
  endfunction

  task automatic check_rd(input int p, input logic [17:0] a);
    string rq = (p == 1 || p == 3) ? "R4" : "R3";
    chk(rsp_valid && !rsp_err && rsp_id == 2'(p), rq, {rsp_valid, rsp_err, rsp_id}, {2'b10, 2'(p)});
    chk(rsp_data == exp_rd(p, a), rq, rsp_data, exp_rd(p, a));
  endtask

  // one request from one port, called away from the rising edge
  task automatic issue(input int p, input bit we_in, input logic [17:0] a,
                       input logic [127:0] nd, input logic [15:0] be, input logic [1023:0] wd);
    bit wide = (p == 1 || p == 3);
    bit we = we_in && (p != 3);
    bit misal = wide && (a[6:0] != 0);
    drive(p, 1, we, a, nd, be, wd);
    #1;
    while (!gnt_of(p)) begin @(negedge clk); #1; end
    if (we && !misal) begin
      if (wide) ref_wide(a, wd);
      else ref_narrow(a, nd, be);
    end
    @(negedge clk);
    drive(p, 0, 0, a, nd, be, wd);
    #1;
    if (misal)
      chk(rsp_err && !rsp_valid && rsp_id == 2'(p), "R5", {rsp_err, rsp_valid, rsp_id}, {2'b10, 2'(p)});
    else if (we)
      chk(!rsp_valid && !rsp_err, "R6", {rsp_valid, rsp_err}, 0);
    else
      check_rd(p, a);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [1023:0] wd;
    logic [127:0]  nd;
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0;
    for (int p = 0; p < 4; p++) drive(p, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    #1;
    // R1 during reset
    chk(!rsp_valid && !rsp_err, "R1", {rsp_valid, rsp_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!rsp_valid && !rsp_err && !mmio_gnt && !dma_gnt && !ld_gnt && !if_gnt, "R1",
        {rsp_valid, rsp_err, mmio_gnt, dma_gnt, ld_gnt, if_gnt}, 0);

    // R9: fill the checked region with wide writes
    for (int r = 0; r < REF_BYTES / 128; r++) begin
      for (int k = 0; k < 32; k++) wd[k*32 +: 32] = $urandom;
      issue(1, 1, 18'(r * 128), 0, 0, wd);
    end

    // R2: all four read at once, expect order 0,1,2,3
    @(negedge clk);
    drive(0, 1, 0, 18'h013, 0, 0, 0);
    drive(1, 1, 0, 18'h080, 0, 0, 0);
    drive(2, 1, 0, 18'h2a7, 0, 0, 0);
    drive(3, 1, 0, 18'h400, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      logic [17:0] ka;
      #1;
      chk({if_gnt, ld_gnt, dma_gnt, mmio_gnt} == 4'(1 << k), "R2",
          {if_gnt, ld_gnt, dma_gnt, mmio_gnt}, 4'(1 << k));
      ka = (k == 0) ? 18'h013 : (k == 1) ? 18'h080 : (k == 2) ? 18'h2a7 : 18'h400;
      @(negedge clk);
      drive(k, 0, 0, ka, 0, 0, 0);
      #1;
      check_rd(k, ka);
    end

    // R3: unaligned narrow read returns the containing line
    issue(2, 0, 18'h035, 0, 0, 0);

    // R6: aligned full write, fetch granted right after
    nd = {$urandom, $urandom, $urandom, $urandom};
    issue(0, 1, 18'h040, nd, 16'hffff, 0);
    drive(3, 1, 0, 18'h000, 0, 0, 0);
    #1;
    chk(if_gnt, "R6", if_gnt, 1);
    @(negedge clk);
    drive(3, 0, 0, 0, 0, 0, 0);
    #1;
    check_rd(3, 18'h000);

    // R7/R8: unaligned write spilling past the line end, fetch waits one cycle
    nd = {$urandom, $urandom, $urandom, $urandom};
    issue(2, 1, 18'h10c, nd, 16'hffff, 0);
    drive(3, 1, 0, 18'h100, 0, 0, 0);
    #1;
    chk(!if_gnt, "R7", if_gnt, 0);
    @(negedge clk);
    #1;
    chk(if_gnt, "R7", if_gnt, 1);
    @(negedge clk);
    drive(3, 0, 0, 0, 0, 0, 0);
    #1;
    chk(rsp_data == exp_block(18'h100), "R8", rsp_data, exp_block(18'h100));

    // R8: partial mask on an aligned line
    nd = {$urandom, $urandom, $urandom, $urandom};
    issue(0, 1, 18'h200, nd, 16'h00f0, 0);
    issue(2, 0, 18'h200, 0, 0, 0);
    issue(1, 0, 18'h200, 0, 0, 0);

    // R5: misaligned wide write leaves memory alone, misaligned fetch errs
    for (int k = 0; k < 32; k++) wd[k*32 +: 32] = $urandom;
    issue(1, 1, 18'h310, 0, 0, wd);
    issue(3, 0, 18'h300, 0, 0, 0);
    issue(3, 0, 18'h388, 0, 0, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int p = $urandom_range(0, 3);
      bit we = (p != 3) && ($urandom_range(0, 1) == 1);
      logic [17:0] a = 18'($urandom_range(0, REF_BYTES - 1));
      logic [15:0] be = ($urandom_range(0, 2) == 0) ? 16'hffff : 16'($urandom);
      if ((p == 1 || p == 3) && $urandom_range(0, 9) != 0) a[6:0] = 0;
      if ((p == 0 || p == 2) && $urandom_range(0, 1) == 0) a[3:0] = 0;
      nd = {$urandom, $urandom, $urandom, $urandom};
      for (int k = 0; k < 32; k++) wd[k*32 +: 32] = $urandom;
      issue(p, we, a, nd, be, wd);
    end

    // final sweep of the region
    for (int r = 0; r < REF_BYTES / 128; r++) issue(3, 0, 18'(r * 128), 0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule